// File: doc/BRIEF.md
# Decimal ASCII Frame Streamer

This block keeps an event count in binary-coded decimal and reports it to a host as a line of text. Each line holds ten ASCII decimal digits, leading zeros included, followed by a line-feed byte. The bytes leave one at a time on an 8-bit data output, paced by an active-low ready input from a byte FIFO. Holding the count in decimal digits means no binary-to-decimal divider is needed. A small lookup maps each digit to its character code.

At the start of each line, the count is copied into a snapshot register. The sequencer then walks a byte index from 0 up to 10. For each byte it shows the data, waits until ready is low, pulses the write strobe for one clock and holds the data for one more clock. After the line feed has been written, the count advances by one and the next line begins. The count runs over the full 32-bit range and wraps from 4294967295 to zero.

The sequencer has four states:
- LOAD: takes the snapshot and clears the index, then goes to SETUP.
- SETUP: shows the byte and moves to STROBE once ready is sampled low.
- STROBE: raises the write strobe, then goes to HOLD.
- HOLD: keeps the data on the output. From HOLD the sequencer goes to SETUP with the index plus one, or to LOAD after the line feed, bumping the count.

Reset puts the sequencer in LOAD.

Top module: `dec_ascii_streamer`

## Requirements
- R1: While reset is active the write strobe is low. The first line after reset carries the start value, which is zero by default.
- R2: Every line is exactly 11 bytes: ten digit bytes, then the line-feed byte 0x0A.
- R3: Digits go out most significant first, each as 0x30 plus the digit value, with leading zeros sent as 0x30.
- R4: The write strobe is high in a cycle only if the ready input was sampled low at the clock edge that started that cycle. While ready stays high, no byte is written.
- R5: The write strobe lasts one clock per byte. The data output holds the same value in the cycle before the strobe, during it and in the cycle after it.
- R6: Successive lines carry successive count values: the count advances by exactly one after the line feed of each line has been written.
- R7: The decimal increment carries through any run of trailing nines (999999999 is followed by 1000000000). No digit ever holds a value above 9.
- R8: The line after 4294967295 carries 0000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ready_n | input | 1 | Low when the downstream FIFO can take a byte |
| wr_strobe | output | 1 | One-clock write pulse per byte |
| tx_byte | output | 8 | Byte being written (ASCII digit or 0x0A) |

## Verification
The assertions check the following on every clock:
- The strobe never fires without a preceding ready-low sample and never lasts two cycles.
- The data stays steady around each strobe.
- The byte index never passes the line-feed position, and every digit stays in 0 to 9.
- The counter holds its value between bumps and wraps correctly at the 32-bit limit.

Only the bench scenarios can show whether whole lines carry the right text in the right order. The bench runs randomly throttled ready patterns, a long stall, the 9-to-10 and 99-to-100 carries, a deep carry across nine digits and the 32-bit wrap. It compares every byte against text built from a reference count.

// File: rtl/das_pkg.sv
`timescale 1ns/1ps
package das_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } das_state_e;

    localparam logic [7:0] CHAR_ZERO    = 8'h30;
    localparam logic [7:0] CHAR_NEWLINE = 8'h0A;
    localparam logic [7:0] CHAR_BAD     = 8'h3F;

endpackage

// File: rtl/dec_bcd_counter.sv
`timescale 1ns/1ps
module dec_bcd_counter #(
    parameter int unsigned       NUM_DIGITS  = 10,
    parameter longint unsigned   START_VALUE = 64'd0,
    parameter longint unsigned   LIMIT_VALUE = 64'd4294967295
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bump,
    output logic [NUM_DIGITS-1:0][3:0]   digits
);

    typedef logic [NUM_DIGITS-1:0][3:0] bcd_t;

    function automatic bcd_t to_bcd(longint unsigned value);
        bcd_t            r;
        longint unsigned t;
        t = value;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            r[i] = 4'(t % 64'd10);
            t    = t / 64'd10;
        end
        return r;
    endfunction

    localparam bcd_t START_BCD = to_bcd(START_VALUE);
    localparam bcd_t LIMIT_BCD = to_bcd(LIMIT_VALUE);

    logic [NUM_DIGITS:0] carry;
    logic                at_limit;

    assign carry[0] = bump;
    assign at_limit = (digits == LIMIT_BCD);

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        assign carry[i+1] = carry[i] && (digits[i] == 4'd9);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                digits[i] <= START_BCD[i];
            end else if (bump && at_limit) begin
                digits[i] <= 4'd0;
            end else if (carry[i]) begin
                digits[i] <= (digits[i] == 4'd9) ? 4'd0 : digits[i] + 4'd1;
            end
        end

        // R7: a digit never leaves the decimal range
        a_r7_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            digits[i] <= 4'd9);
    end

    // R6: the count only moves when bumped
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(digits));

    // R8: bumping at the limit lands on zero
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && at_limit) |=> (digits == '0));

    // R7: a units nine rolls to zero when bumped below the limit
    a_r7_units_roll: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !at_limit && digits[0] == 4'd9) |=> (digits[0] == 4'd0));

endmodule

// File: rtl/dec_byte_mux.sv
`timescale 1ns/1ps
module dec_byte_mux
    import das_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 10,
    parameter int unsigned IDX_W      = $clog2(NUM_DIGITS + 1)
) (
    input  logic [NUM_DIGITS-1:0][3:0] snap,
    input  logic [IDX_W-1:0]           byte_idx,
    output logic [7:0]                 out_byte
);

    logic [7:0] glyph [10];
    logic [3:0] sel_digit;

    for (genvar g = 0; g < 10; g++) begin : g_glyph
        assign glyph[g] = CHAR_ZERO + 8'(g);
    end

    always_comb begin
        sel_digit = 4'd0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (int'(byte_idx) == NUM_DIGITS - 1 - k) begin
                sel_digit = snap[k];
            end
        end
    end

    always_comb begin
        if (int'(byte_idx) >= NUM_DIGITS) begin
            out_byte = CHAR_NEWLINE;
        end else if (sel_digit <= 4'd9) begin
            out_byte = glyph[sel_digit];
        end else begin
            out_byte = CHAR_BAD;
        end
    end

endmodule

// File: rtl/dec_frame_fsm.sv
`timescale 1ns/1ps
module dec_frame_fsm
    import das_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 10,
    parameter int unsigned IDX_W      = $clog2(NUM_DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_ready_n,
    output logic             wr_strobe,
    output logic             snap_load,
    output logic             frame_done,
    output logic [IDX_W-1:0] byte_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS);

    das_state_e state, next_state;
    logic       last_byte;

    assign last_byte = (byte_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_LOAD:   next_state = ST_SETUP;
            ST_SETUP:  next_state = tx_ready_n ? ST_SETUP : ST_STROBE;
            ST_STROBE: next_state = ST_HOLD;
            ST_HOLD:   next_state = last_byte ? ST_LOAD : ST_SETUP;
            default:   next_state = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
        end else if (state == ST_LOAD) begin
            byte_idx <= '0;
        end else if (state == ST_HOLD && !last_byte) begin
            byte_idx <= byte_idx + IDX_W'(1);
        end
    end

    always_comb begin
        wr_strobe  = (state == ST_STROBE);
        snap_load  = (state == ST_LOAD);
        frame_done = (state == ST_HOLD) && last_byte;
    end

    // R4: a write needs ready sampled low on the edge before it
    a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(!tx_ready_n));

    // R5: the strobe is a single clock wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R2: the index never passes the line-feed slot
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= LAST_IDX);

    // R2: a line closes only after eleven positions, then restarts at zero
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (snap_load && byte_idx == LAST_IDX));

endmodule

// File: rtl/dec_ascii_streamer.sv
`timescale 1ns/1ps
module dec_ascii_streamer #(
    parameter int unsigned     NUM_DIGITS  = 10,
    parameter longint unsigned START_VALUE = 64'd0,
    parameter longint unsigned LIMIT_VALUE = 64'd4294967295
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_ready_n,
    output logic       wr_strobe,
    output logic [7:0] tx_byte
);

    localparam int unsigned IDX_W = $clog2(NUM_DIGITS + 1);

    logic [NUM_DIGITS-1:0][3:0] count_digits;
    logic [NUM_DIGITS-1:0][3:0] snap_digits;
    logic [IDX_W-1:0]           byte_idx;
    logic                       snap_load;
    logic                       frame_done;

    dec_bcd_counter #(
        .NUM_DIGITS  (NUM_DIGITS),
        .START_VALUE (START_VALUE),
        .LIMIT_VALUE (LIMIT_VALUE)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (frame_done),
        .digits (count_digits)
    );

    dec_frame_fsm #(
        .NUM_DIGITS (NUM_DIGITS),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_ready_n (tx_ready_n),
        .wr_strobe  (wr_strobe),
        .snap_load  (snap_load),
        .frame_done (frame_done),
        .byte_idx   (byte_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_digits <= '0;
        end else if (snap_load) begin
            snap_digits <= count_digits;
        end
    end

    dec_byte_mux #(
        .NUM_DIGITS (NUM_DIGITS),
        .IDX_W      (IDX_W)
    ) u_mux (
        .snap     (snap_digits),
        .byte_idx (byte_idx),
        .out_byte (tx_byte)
    );

    // R5: data already steady in the cycle before the strobe
    a_r5_data_before: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $stable(tx_byte));

    // R5: data still steady in the cycle after the strobe
    a_r5_data_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_strobe) |-> $stable(tx_byte));

    // R3: digit slots always carry a decimal character
    a_r3_digit_char: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && int'(byte_idx) < NUM_DIGITS) |->
            (tx_byte >= 8'h30 && tx_byte <= 8'h39));

    // R1: no write while in reset
    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |-> !wr_strobe);

endmodule

// File: tb/dec_ascii_streamer_tb.sv
`timescale 1ns/1ps
module streamer_tb_mon #(
    parameter longint unsigned START = 64'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] data,
    input  logic       stall,
    output logic       rdy_n
);
    int              checks  = 0;
    int              fails   = 0;
    int              frames  = 0;
    int              strobes = 0;
    int              bpos    = 0;
    longint unsigned expv    = START;
    logic            prev_rdy_n = 1'b1;
    logic [7:0]      prev_data  = 8'h00;
    logic [7:0]      last_data  = 8'h00;
    logic            after_stb  = 1'b0;

    initial rdy_n = 1'b1;

    always @(posedge clk) begin
        #2;
        rdy_n = stall ? 1'b1 : (($urandom % 4) == 0);
    end

    function automatic logic [7:0] exp_byte(longint unsigned v, int pos);
        longint unsigned p;
        if (pos >= 10) return 8'h0A;
        p = 1;
        for (int k = 0; k < 9 - pos; k++) p = p * 10;
        return 8'h30 + 8'((v / p) % 10);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (start %0d, frame %0d, byte %0d)",
                     req, act, exp, START, frames, bpos);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (after_stb) begin
                chk(!wr_stb, "R5 pulse width", 64'(wr_stb), 64'd0);
                chk(data == last_data, "R5 hold after", 64'(data), 64'(last_data));
                after_stb = 1'b0;
            end
            if (wr_stb) begin
                strobes++;
                chk(prev_rdy_n == 1'b0, "R4 ready gate", 64'(prev_rdy_n), 64'd0);
                chk(data == prev_data, "R5 setup before", 64'(data), 64'(prev_data));
                // R2 line feed slot, R3 digit bytes, R6/R7/R8 via expv
                chk(data == exp_byte(expv, bpos), (bpos == 10) ? "R2 line feed" : "R3 digit byte",
                    64'(data), 64'(exp_byte(expv, bpos)));
                last_data = data;
                after_stb = 1'b1;
                bpos++;
                if (bpos == 11) begin
                    bpos = 0;
                    frames++;
                    expv = (expv + 1) & 64'hFFFF_FFFF;
                end
            end
            prev_rdy_n = rdy_n;
            prev_data  = data;
        end
    end
endmodule

module dec_ascii_streamer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall0 = 1'b0;
    always #4 clk = ~clk;

    logic       rdy0_n, rdy1_n, rdy2_n;
    logic       stb0, stb1, stb2;
    logic [7:0] dat0, dat1, dat2;

    int checks = 0;
    int fails  = 0;

    dec_ascii_streamer u_dut (
        .clk(clk), .rst_n(rst_n), .tx_ready_n(rdy0_n), .wr_strobe(stb0), .tx_byte(dat0));
    dec_ascii_streamer #(.START_VALUE(64'd999999998)) u_dut_carry (
        .clk(clk), .rst_n(rst_n), .tx_ready_n(rdy1_n), .wr_strobe(stb1), .tx_byte(dat1));
    dec_ascii_streamer #(.START_VALUE(64'd4294967290)) u_dut_wrap (
        .clk(clk), .rst_n(rst_n), .tx_ready_n(rdy2_n), .wr_strobe(stb2), .tx_byte(dat2));

    streamer_tb_mon #(.START(64'd0)) u_mon0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(stb0), .data(dat0), .stall(stall0), .rdy_n(rdy0_n));
    streamer_tb_mon #(.START(64'd999999998)) u_mon1 (
        .clk(clk), .rst_n(rst_n), .wr_stb(stb1), .data(dat1), .stall(1'b0), .rdy_n(rdy1_n));
    streamer_tb_mon #(.START(64'd4294967290)) u_mon2 (
        .clk(clk), .rst_n(rst_n), .wr_stb(stb2), .data(dat2), .stall(1'b0), .rdy_n(rdy2_n));

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_test();
        int n0;
        // R1: strobes stay low through reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!stb0 && !stb1 && !stb2, "R1 strobe in reset", int'(stb0 | stb1 | stb2), 0);
        end
        rst_n = 1'b1;
        wait (u_mon0.frames >= 1);
        @(negedge clk);
        chk(u_mon0.fails == 0, "R1 first line carries start value", u_mon0.fails, 0);
        wait (u_mon0.frames >= 2);
        // R4: long stall, no write may slip through
        @(posedge clk);
        stall0 = 1'b1;
        repeat (3) @(negedge clk);
        n0 = u_mon0.strobes;
        repeat (60) @(negedge clk);
        chk(u_mon0.strobes == n0, "R4 no write while not ready", u_mon0.strobes, n0);
        stall0 = 1'b0;
        wait (u_mon0.frames >= 105 && u_mon1.frames >= 3 && u_mon2.frames >= 8);
        @(negedge clk);
        chk(u_mon0.fails == 0, "R6 consecutive lines 0..104", u_mon0.fails, 0);
        chk(u_mon1.fails == 0, "R7 deep carry 999999999 to 1000000000", u_mon1.fails, 0);
        chk(u_mon2.fails == 0, "R8 wrap 4294967295 to 0", u_mon2.fails, 0);
        chk(u_mon2.strobes >= 88, "R2 eleven bytes per line", u_mon2.strobes, 88);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            run_test();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        checks += u_mon0.checks + u_mon1.checks + u_mon2.checks;
        fails  += u_mon0.fails + u_mon1.fails + u_mon2.fails;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule